// File: doc/BRIEF.md
# XOR-Encoded Two-Write-Port RAM

This block is a memory with two independent write ports and one read port. It is built only from simple banks, each with one write port and one synchronous read port, and it has no flip-flop storage array. Each write port owns a group of two banks, and both banks in a group always hold the same data. One bank in each group serves the read port. The other bank is read by the opposite write port.

A write through one port goes through two steps. First it looks up the other port's group at the same address. On the next cycle it stores the new data XORed with that value into its own group. Because a xor b xor b equals a, XORing the two groups' contents at an address recovers the value written last, whichever port wrote it.

Each bank has a write-first bypass. The top level forwards a write that is requested in the same cycle as a read. Together these keep the visible behaviour of a plain RAM: data comes back one cycle after the read request, and a read in the same cycle as a write to that address returns the new value.

Top module: `xor_mpram`

## Requirements
- R1: The value on `rd_data` in the cycle after `rd_en` is the value most recently written to `rd_addr` through either port, with last-writer-wins ordering across ports.
- R2: After reset, `rd_data` is zero, and every location that has not been written reads as zero.
- R3: Writing 0x1111 through port 0 and then 0x2222 through port 1 to the same address makes a later read of that address return 0x2222. A read between the two writes returns 0x1111.
- R4: A read that is requested in the same cycle as a port-0 write to the same address returns the port-0 write data one cycle later.
- R5: A read that is requested in the same cycle as a port-1 write to the same address, with no port-0 write to that address, returns the port-1 write data one cycle later.
- R6: A read requested in the cycle right after a write to the same address returns the new value, even though that write is still being committed to the banks in that cycle.
- R7: Writes to one address in consecutive cycles through alternating ports leave that address holding the last of them.
- R8: While `rd_en` is low, `rd_data` holds its value, even when writes change the location that was last read.
- R9: Each write is committed to its port's bank group exactly one cycle after it is requested, at the requested address.
- R10: Writes through both ports in the same cycle to different addresses are both kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the pipeline registers |
| wr0_en | input | 1 | Write enable, port 0 |
| wr0_addr | input | ADDR_W | Write address, port 0 |
| wr0_data | input | DATA_W | Write data, port 0 |
| wr1_en | input | 1 | Write enable, port 1 |
| wr1_addr | input | ADDR_W | Write address, port 1 |
| wr1_data | input | DATA_W | Write data, port 1 |
| rd_en | input | 1 | Read enable |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data, valid the cycle after `rd_en` |

## Verification
The bench uses the defaults, ADDR_W = 4 and DATA_W = 16. With only sixteen locations, a long pseudo-random run hits the same addresses again and again. That makes it likely that the run produces the collisions that stress the encoding: alternating-port rewrites, reads of a location that is still being committed, and same-cycle read/write forwarding. Sixteen-bit data is wide enough to carry distinct patterns such as 0x1111 and 0x2222, so a wrong XOR operand cannot cancel out unnoticed.

// File: rtl/xram_pkg.sv
package xram_pkg;
    localparam int NUM_WR = 2;

    // index of the write port whose group a given port must consult
    function automatic int peer(input int p);
        return NUM_WR - 1 - p;
    endfunction
endpackage

// File: rtl/xram_bank.sv
module xram_bank #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [DATA_W-1:0] rdat;
        logic              hit;
        logic [DATA_W-1:0] fwd;
    } bank_st_t;

    logic [DATA_W-1:0] mem [DEPTH];
    bank_st_t st_d, st_q;

    // power-up contents are zero, as an FPGA block RAM allows
    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    end

    always_comb begin
        st_d = st_q;
        if (re) begin
            st_d.rdat = mem[raddr];
            st_d.hit  = we && (waddr == raddr);
            if (we && (waddr == raddr)) st_d.fwd = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = st_q.hit ? st_q.fwd : st_q.rdat;

    // a read colliding with a write to the same address sees the new data
    assert_bank_wfirst_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (we && re && (waddr == raddr)) |=> (rdata == $past(wdata)));
endmodule

// File: rtl/xram_wport.sv
module xram_wport #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] peer_rdata,
    output logic              cm_we,
    output logic [ADDR_W-1:0] cm_addr,
    output logic [DATA_W-1:0] cm_data
);
    typedef struct packed {
        logic              v;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wp_st_t;

    wp_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        st_d.v = wr_en;
        if (wr_en) begin
            st_d.addr = wr_addr;
            st_d.data = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cm_we   = st_q.v;
    assign cm_addr = st_q.addr;
    assign cm_data = st_q.data ^ peer_rdata;

    assert_commit_next_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cm_we && (cm_addr == $past(wr_addr))));
    assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> !cm_we);
endmodule

// File: rtl/xor_mpram.sv
module xor_mpram #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr0_en,
    input  logic [ADDR_W-1:0] wr0_addr,
    input  logic [DATA_W-1:0] wr0_data,
    input  logic              wr1_en,
    input  logic [ADDR_W-1:0] wr1_addr,
    input  logic [DATA_W-1:0] wr1_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    import xram_pkg::*;

    typedef struct packed {
        logic [NUM_WR-1:0]             hit;
        logic [NUM_WR-1:0][DATA_W-1:0] fwd;
    } top_st_t;

    logic [NUM_WR-1:0]             wen;
    logic [NUM_WR-1:0][ADDR_W-1:0] wad;
    logic [NUM_WR-1:0][DATA_W-1:0] wdt;
    logic [NUM_WR-1:0]             cm_we;
    logic [NUM_WR-1:0][ADDR_W-1:0] cm_addr;
    logic [NUM_WR-1:0][DATA_W-1:0] cm_data;
    logic [NUM_WR-1:0][DATA_W-1:0] fb_out;
    logic [NUM_WR-1:0][DATA_W-1:0] rd_out;
    top_st_t st_d, st_q;

    assign wen = {wr1_en, wr0_en};
    assign wad = {wr1_addr, wr0_addr};
    assign wdt = {wr1_data, wr0_data};

    for (genvar p = 0; p < NUM_WR; p++) begin : g_port
        localparam int PEER = peer(p);

        xram_wport #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wport (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (wen[p]),
            .wr_addr   (wad[p]),
            .wr_data   (wdt[p]),
            .peer_rdata(fb_out[PEER]),
            .cm_we     (cm_we[p]),
            .cm_addr   (cm_addr[p]),
            .cm_data   (cm_data[p])
        );

        // bank of group p read by the peer port's incoming write
        xram_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fb_bank (
            .clk  (clk),
            .rst_n(rst_n),
            .we   (cm_we[p]),
            .waddr(cm_addr[p]),
            .wdata(cm_data[p]),
            .re   (wen[PEER]),
            .raddr(wad[PEER]),
            .rdata(fb_out[p])
        );

        // bank of group p serving the read port
        xram_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd_bank (
            .clk  (clk),
            .rst_n(rst_n),
            .we   (cm_we[p]),
            .waddr(cm_addr[p]),
            .wdata(cm_data[p]),
            .re   (rd_en),
            .raddr(rd_addr),
            .rdata(rd_out[p])
        );
    end

    always_comb begin
        st_d = st_q;
        if (rd_en) begin
            for (int p = 0; p < NUM_WR; p++) begin
                st_d.hit[p] = wen[p] && (wad[p] == rd_addr);
                if (wen[p] && (wad[p] == rd_addr)) st_d.fwd[p] = wdt[p];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // port 0 forwarding takes precedence over port 1, then the decoded value
    always_comb begin
        rd_data = '0;
        for (int p = 0; p < NUM_WR; p++) rd_data = rd_data ^ rd_out[p];
        for (int p = NUM_WR - 1; p >= 0; p--) begin
            if (st_q.hit[p]) rd_data = st_q.fwd[p];
        end
    end

    assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
    assert_fwd_p0_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && wr0_en && (wr0_addr == rd_addr)) |=> (rd_data == $past(wr0_data)));
    assert_fwd_p1_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && wr1_en && (wr1_addr == rd_addr) && !(wr0_en && (wr0_addr == rd_addr)))
        |=> (rd_data == $past(wr1_data)));
endmodule

// File: tb/xor_mpram_tb.sv
module xor_mpram_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 4;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr0_en = 1'b0, wr1_en = 1'b0, rd_en = 1'b0;
    logic [AW-1:0] wr0_addr = '0, wr1_addr = '0, rd_addr = '0;
    logic [DW-1:0] wr0_data = '0, wr1_data = '0;
    logic [DW-1:0] rd_data;

    logic [DW-1:0] ref_mem [1<<AW];
    int total = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xor_mpram #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .wr0_en(wr0_en), .wr0_addr(wr0_addr), .wr0_data(wr0_data),
        .wr1_en(wr1_en), .wr1_addr(wr1_addr), .wr1_data(wr1_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: rd_data=%h expected %h", req, act, exp);
        end
    endtask

    // one clock: drive at negedge, model write-first, check output after the edge
    task automatic cyc(input logic w0, input logic [AW-1:0] a0, input logic [DW-1:0] d0,
                       input logic w1, input logic [AW-1:0] a1, input logic [DW-1:0] d1,
                       input logic re, input logic [AW-1:0] ra, input string req);
        logic [DW-1:0] exp;
        @(negedge clk);
        wr0_en = w0; wr0_addr = a0; wr0_data = d0;
        wr1_en = w1; wr1_addr = a1; wr1_data = d1;
        rd_en = re;  rd_addr = ra;
        if (w0) ref_mem[a0] = d0;
        if (w1) ref_mem[a1] = d1;
        exp = ref_mem[ra];
        @(posedge clk);
        #1;
        if (re) check(req, rd_data, exp);
    endtask

    task automatic idle();
        cyc(1'b0, '0, '0, 1'b0, '0, '0, 1'b0, '0, "");
    endtask

    task automatic t_reset();
        for (int i = 0; i < (1<<AW); i++) ref_mem[i] = '0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R2 reset output", rd_data, '0);
        cyc(1'b0, '0, '0, 1'b0, '0, '0, 1'b1, 4'd3, "R2 unwritten reads zero");
    endtask

    task automatic t_encode_example();
        cyc(1'b1, 4'd2, 16'h1111, 1'b0, '0, '0, 1'b0, '0, "");
        idle();
        cyc(1'b0, '0, '0, 1'b0, '0, '0, 1'b1, 4'd2, "R3 after port0 write");
        cyc(1'b0, '0, '0, 1'b1, 4'd2, 16'h2222, 1'b0, '0, "");
        idle();
        cyc(1'b0, '0, '0, 1'b0, '0, '0, 1'b1, 4'd2, "R3 after port1 write");
        check("R3 value 0x2222", rd_data, 16'h2222);
    endtask

    task automatic t_forward();
        cyc(1'b1, 4'd4, 16'hBEEF, 1'b0, '0, '0, 1'b1, 4'd4, "R4 same-cycle port0");
        cyc(1'b0, '0, '0, 1'b1, 4'd5, 16'hCAFE, 1'b1, 4'd5, "R5 same-cycle port1");
        cyc(1'b1, 4'd6, 16'h0A0A, 1'b0, '0, '0, 1'b0, '0, "");
        cyc(1'b0, '0, '0, 1'b0, '0, '0, 1'b1, 4'd6, "R6 read during commit port0");
        cyc(1'b0, '0, '0, 1'b1, 4'd6, 16'h5050, 1'b0, '0, "");
        cyc(1'b0, '0, '0, 1'b0, '0, '0, 1'b1, 4'd6, "R6 read during commit port1");
    endtask

    task automatic t_alternate();
        cyc(1'b1, 4'd7, 16'hAAAA, 1'b0, '0, '0, 1'b0, '0, "");
        cyc(1'b0, '0, '0, 1'b1, 4'd7, 16'h5555, 1'b0, '0, "");
        cyc(1'b1, 4'd7, 16'h0F0F, 1'b0, '0, '0, 1'b0, '0, "");
        cyc(1'b0, '0, '0, 1'b1, 4'd7, 16'h1234, 1'b1, 4'd7, "R7 alternating with read");
        cyc(1'b0, '0, '0, 1'b0, '0, '0, 1'b1, 4'd7, "R7 alternating settled");
        idle();
        cyc(1'b0, '0, '0, 1'b0, '0, '0, 1'b1, 4'd7, "R7 alternating final");
    endtask

    task automatic t_dual_write();
        cyc(1'b1, 4'd8, 16'h8888, 1'b1, 4'd9, 16'h9999, 1'b0, '0, "");
        idle();
        cyc(1'b0, '0, '0, 1'b0, '0, '0, 1'b1, 4'd8, "R10 dual write port0 kept");
        cyc(1'b0, '0, '0, 1'b0, '0, '0, 1'b1, 4'd9, "R10 dual write port1 kept");
    endtask

    task automatic t_hold();
        logic [DW-1:0] held;
        cyc(1'b0, '0, '0, 1'b0, '0, '0, 1'b1, 4'd9, "R8 initial read");
        held = rd_data;
        cyc(1'b1, 4'd9, 16'h7777, 1'b0, '0, '0, 1'b0, '0, "");
        check("R8 hold after port0 write", rd_data, held);
        cyc(1'b0, '0, '0, 1'b1, 4'd9, 16'h6666, 1'b0, '0, "");
        check("R8 hold after port1 write", rd_data, held);
        idle();
        check("R8 hold idle", rd_data, held);
        cyc(1'b0, '0, '0, 1'b0, '0, '0, 1'b1, 4'd9, "R8 new value visible on read");
    endtask

    task automatic t_random();
        logic [15:0] x = 16'hACE1;
        for (int n = 0; n < 400; n++) begin
            logic [AW-1:0] a0, a1;
            logic w0, w1;
            x = {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
            w0 = x[0];
            w1 = x[1];
            a0 = x[5:2];
            a1 = x[9:6];
            if (w0 && w1 && (a0 == a1)) a1 = a0 + 4'd1;
            cyc(w0, a0, {x[7:0], x[15:8]}, w1, a1, x ^ 16'h3C3C,
                x[10] | x[11], x[14:11], "R1 random last-writer");
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        t_reset();
        t_encode_example();
        t_forward();
        t_alternate();
        t_dual_write();
        t_hold();
        t_random();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule